// File: doc/BRIEF.md
# Serial Bitstream Configuration Master

This block loads a configuration image into a target device over a one-bit serial link. A single start pulse, together with a byte count, begins a load. The block first runs the reset handshake with the target. It drives the target's active-low program line low and waits for the target to pull its init line low. It then releases the program line and waits for init to return high. Once the handshake is done, it takes image bytes from a valid/ready stream and shifts each one out on a data line, most significant bit first. The target samples each bit on a rising edge of a configuration clock that the block generates.

Before it accepts each byte, the block checks for an integrity fault: init pulled low while done is still low. When all bytes have gone out, it holds the data line high and keeps toggling the configuration clock until the target raises done. A three-bit status output reports the outcome of the last operation, and that value stays until the next request. Both target inputs pass through two-flop synchronizers before any logic uses them. A readback request is refused with its own status code, because this serial mode cannot read back.

Back-pressure rules: `s_ready` is high only while the block waits for the next byte of an active load. A byte transfers on a clock edge where `s_valid` and `s_ready` are both high. Exactly `byte_count` bytes are taken. The source may hold `s_valid` low for as long as it likes. During such a stall the configuration clock rests low and no timer runs.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, and whenever no load is active, the block holds `tgt_prog_n`=1, `tgt_cclk`=0, `tgt_din`=1 and `s_ready`=0. The idle status code is 0.
- R2: A `start` pulse in idle sets status to 1 (busy) on the next clock and drives `tgt_prog_n` low. The program line stays low until the synchronized init line reads low.
- R3: If init does not go low within WAIT_CYC cycles while the program line is low, the load ends with status 3. The same status results if init does not return high within WAIT_CYC cycles after the program line is released. The program line is high again afterwards.
- R4: Exactly `byte_count` bytes are sent, each as 8 rising edges of `tgt_cclk`, with bit 7 first and bit 0 last. A count of zero skips straight to the trailing clocks.
- R5: Each bit cycle drives `tgt_cclk` low for HALF_CYC cycles with the bit on `tgt_din`, then high for HALF_CYC cycles. `tgt_din` never changes on the cycle where `tgt_cclk` rises.
- R6: Before each byte is accepted, the block checks for synchronized init low together with done low. If it finds that condition, the load stops with status 4 and takes no further bytes.
- R7: After the last byte, `tgt_din` stays 1 on every rising edge of `tgt_cclk`. The clock keeps toggling until the synchronized done line reads high, and the load then ends with status 2.
- R8: If done does not rise within WAIT_CYC cycles of the end of the data, the load ends with status 5.
- R9: A `rb_req` pulse in idle, with `start` low, sets status 6. No target pin moves.
- R10: The status value of a finished load or request holds until the next `start` or `rb_req` in idle.
- R11: `s_ready` is high only while status is 1 and the block is waiting for a byte. The block takes one byte per handshake and never more than `byte_count` bytes per load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle load request; sampled only in idle |
| rb_req | input | 1 | One-cycle readback request; always refused |
| byte_count | input | CNT_W | Number of image bytes, captured with `start` |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Block can take a byte this cycle |
| tgt_prog_n | output | 1 | Active-low program request to the target |
| tgt_cclk | output | 1 | Configuration clock to the target |
| tgt_din | output | 1 | Serial configuration data to the target |
| tgt_init_n | input | 1 | Target init line (low = clearing or error) |
| tgt_done | input | 1 | Target done line (high = configured) |
| status | output | 3 | 0 idle, 1 busy, 2 ok, 3 init timeout, 4 CRC error, 5 done timeout, 6 readback refused |

## Verification
The main load runs with random byte values, random counts and random gaps in `s_valid`, against a bench model of the target that samples data on each rising configuration clock. Matching the received bytes shows the bit order and the count. Dense stalls show that back-pressure does not drop or repeat bytes. One extra byte offered after the count shows that the block stops taking data once the count is reached. Directed patterns each isolate one exit path: an init line that never falls, one that never rises, an init fault injected after a chosen byte, a done line that never rises, and a zero-byte load. Each exit must produce its own status code and the matching number of consumed bytes.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_BUSY     = 3'd1,
    ST_OK       = 3'd2,
    ST_INIT_TMO = 3'd3,
    ST_CRC_ERR  = 3'd4,
    ST_DONE_TMO = 3'd5,
    ST_RB_REJ   = 3'd6
  } cfg_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PROG_LO,
    S_WAIT_HI,
    S_FETCH,
    S_SHIFT,
    S_TRAIL
  } cfg_fsm_e;

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= {2{RST[i]}};
      else        ff_q <= {ff_q[0], d[i]};
    end
    assign q[i] = ff_q[1];
  end
endmodule

// File: rtl/cfgl_cclk_gen.sv
module cfgl_cclk_gen #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic cclk,
  output logic period_end
);
  localparam int LW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [LW-1:0] LAST = LW'(HALF_CYC - 1);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cclk  <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      cclk  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      cclk  <= ~cclk;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // end of the high half: the bit just sampled is finished
  assign period_end = en && cclk && (cnt_q == LAST);
endmodule

// File: rtl/cfgl_shreg.sv
module cfgl_shreg
  import cfgl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] d,
  output logic              msb,
  output logic              last_bit
);
  localparam int BW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic [BW-1:0]     idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= d;
      idx_q <= '0;
    end else if (shift) begin
      sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign msb      = sh_q[BYTE_W-1];
  assign last_bit = (idx_q == BW'(BYTE_W - 1));
endmodule

// File: rtl/cfgl_timer.sv
module cfgl_timer #(
  parameter int LIMIT = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] TOP = TW'(LIMIT);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clr)                cnt_q <= '0;
    else if (run && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == TOP);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgl_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int WAIT_CYC = 500000,
  parameter int CNT_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rb_req,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  output logic             s_ready,
  output logic             tgt_prog_n,
  output logic             tgt_cclk,
  output logic             tgt_din,
  input  logic             tgt_init_n,
  input  logic             tgt_done,
  output logic [2:0]       status
);
  cfg_fsm_e        st_q, st_d;
  cfg_status_e     stat_q, stat_d;
  logic [CNT_W-1:0] rem_q, rem_d;

  logic init_s, done_s;
  logic tick, expired;
  logic sh_load, sh_shift, sh_msb, sh_last;

  cfgl_sync #(.W(2), .RST(2'b01)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({tgt_done, tgt_init_n}),
    .q    ({done_s, init_s})
  );

  cfgl_cclk_gen #(.HALF_CYC(HALF_CYC)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (st_q inside {S_SHIFT, S_TRAIL}),
    .cclk      (tgt_cclk),
    .period_end(tick)
  );

  cfgl_shreg u_sh (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (sh_load),
    .shift   (sh_shift),
    .d       (s_data),
    .msb     (sh_msb),
    .last_bit(sh_last)
  );

  cfgl_timer #(.LIMIT(WAIT_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (st_d != st_q),
    .run    (st_q inside {S_PROG_LO, S_WAIT_HI, S_TRAIL}),
    .expired(expired)
  );

  always_comb begin
    st_d     = st_q;
    stat_d   = stat_q;
    rem_d    = rem_q;
    s_ready  = 1'b0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d   = S_PROG_LO;
          stat_d = ST_BUSY;
          rem_d  = byte_count;
        end else if (rb_req) begin
          stat_d = ST_RB_REJ;
        end
      end
      S_PROG_LO: begin
        if (!init_s) begin
          st_d = S_WAIT_HI;
        end else if (expired) begin
          st_d   = S_IDLE;
          stat_d = ST_INIT_TMO;
        end
      end
      S_WAIT_HI: begin
        if (init_s) begin
          st_d = S_FETCH;
        end else if (expired) begin
          st_d   = S_IDLE;
          stat_d = ST_INIT_TMO;
        end
      end
      S_FETCH: begin
        if (rem_q == '0) begin
          st_d = S_TRAIL;
        end else if (!init_s && !done_s) begin
          st_d   = S_IDLE;
          stat_d = ST_CRC_ERR;
        end else begin
          s_ready = 1'b1;
          if (s_valid) begin
            sh_load = 1'b1;
            rem_d   = rem_q - 1'b1;
            st_d    = S_SHIFT;
          end
        end
      end
      S_SHIFT: begin
        if (tick) begin
          if (sh_last) st_d = S_FETCH;
          else         sh_shift = 1'b1;
        end
      end
      S_TRAIL: begin
        if (done_s) begin
          st_d   = S_IDLE;
          stat_d = ST_OK;
        end else if (expired) begin
          st_d   = S_IDLE;
          stat_d = ST_DONE_TMO;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      stat_q <= ST_IDLE;
      rem_q  <= '0;
    end else begin
      st_q   <= st_d;
      stat_q <= stat_d;
      rem_q  <= rem_d;
    end
  end

  assign tgt_prog_n = (st_q != S_PROG_LO);
  assign tgt_din    = (st_q == S_SHIFT) ? sh_msb : 1'b1;
  assign status     = stat_q;
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       rb_req,
  input logic       s_ready,
  input logic       tgt_prog_n,
  input logic       tgt_cclk,
  input logic       tgt_din,
  input logic [2:0] status
);
  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (status == 3'd1)); // R11

  AST_DIN_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_cclk) |-> $stable(tgt_din)); // R5

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 3'd1 && !start && !rb_req) |=> $stable(status)); // R10

  AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 3'd1 && !start) |=> (!tgt_cclk && tgt_prog_n && tgt_din)); // R1

  AST_PROG_FALL_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_prog_n) |-> $past(start)); // R2
endmodule

bind cfg_serial_loader cfgl_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .rb_req    (rb_req),
  .s_ready   (s_ready),
  .tgt_prog_n(tgt_prog_n),
  .tgt_cclk  (tgt_cclk),
  .tgt_din   (tgt_din),
  .status    (status)
);

// File: tb/sim_cfg_serial_loader.sv
module sim_cfg_serial_loader;
  localparam int HALF = 2;
  localparam int WAIT = 300;
  localparam int CW   = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0, start = 1'b0, rb_req = 1'b0;
  logic [CW-1:0] byte_count = '0;
  logic          s_valid = 1'b0;
  logic [7:0]    s_data = '0;
  logic          s_ready, prog_n, cclk, din;
  logic          init_n = 1'b1, done_t = 1'b0;
  logic [2:0]    status;

  cfg_serial_loader #(.HALF_CYC(HALF), .WAIT_CYC(WAIT), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rb_req(rb_req),
    .byte_count(byte_count), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .tgt_prog_n(prog_n), .tgt_cclk(cclk),
    .tgt_din(din), .tgt_init_n(init_n), .tgt_done(done_t),
    .status(status)
  );

  int errs = 0, checks = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // target model settings (written by the stimulus only)
  bit m_clr = 1'b0, m_resp_lo = 1'b1, m_release = 1'b1;
  int m_done_after = 1, m_crc_at = -1, m_exp_n = 0;
  // target model state (written by the model only)
  int rx_n, bitn, trail_rises, trail_bad, din_bad;
  bit crc_fired, prev_cclk, prev_din;
  logic [7:0] acc;
  logic [7:0] cap [0:63];
  logic [7:0] src [0:63];

  always @(negedge clk) begin
    if (m_clr) begin
      rx_n = 0; bitn = 0; acc = '0; trail_rises = 0; trail_bad = 0;
      din_bad = 0; crc_fired = 1'b0; done_t = 1'b0; init_n = 1'b1;
    end else begin
      if (!prog_n) begin
        init_n = m_resp_lo ? 1'b0 : 1'b1;
        done_t = 1'b0;
      end else if (!init_n && m_release && !crc_fired) begin
        init_n = 1'b1;
      end
      if (cclk && !prev_cclk) begin
        if (din != prev_din) din_bad++;
        if (rx_n < m_exp_n) begin
          acc = {acc[6:0], din};
          bitn++;
          if (bitn == 8) begin
            cap[rx_n] = acc;
            rx_n++;
            bitn = 0;
            if (rx_n == m_crc_at) begin
              crc_fired = 1'b1;
              init_n = 1'b0;
            end
          end
        end else begin
          trail_rises++;
          if (!din) trail_bad++;
          if (trail_rises == m_done_after) done_t = 1'b1;
        end
      end
    end
    prev_cclk = cclk;
    prev_din  = din;
  end

  function automatic int exp_status(int n, int done_after, int crc_at,
                                    bit resp_lo, bit rel);
    if (!resp_lo || !rel) return 3;
    if (crc_at >= 1 && crc_at < n) return 4;
    if (done_after < 1) return 5;
    return 2;
  endfunction

  function automatic int exp_taken(int n, int st, int crc_at);
    if (st == 3) return 0;
    if (st == 4) return crc_at;
    return n;
  endfunction

  bit src_stop;

  task automatic run_load(int n, int dens, int done_after, int crc_at,
                          bit resp_lo, bit rel, string tag);
    int taken = 0;
    int busy_cyc = 0;
    int est;
    m_resp_lo = resp_lo; m_release = rel; m_done_after = done_after;
    m_crc_at = crc_at; m_exp_n = n;
    m_clr = 1'b1;
    repeat (2) @(negedge clk);
    m_clr = 1'b0;
    for (int i = 0; i <= n; i++) src[i] = 8'($urandom);
    src_stop = 1'b0;
    byte_count = CW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(prog_n == 1'b0, "R2", {tag, " program line low after start"}, int'(prog_n), 0);
    chk(status == 3'd1, "R2", {tag, " busy after start"}, int'(status), 1);
    fork
      begin
        int idx = 0;
        bit hs = 1'b0;
        while (!src_stop) begin
          @(negedge clk);
          if (hs) idx++;
          if (idx <= n && int'($urandom % 100) < dens) begin
            s_valid = 1'b1;
            s_data  = src[idx];
          end else begin
            s_valid = 1'b0;
          end
          hs = s_valid && s_ready;
        end
        s_valid = 1'b0;
        taken = idx;
      end
      begin
        while (status == 3'd1 && busy_cyc < 20000) begin
          @(negedge clk);
          busy_cyc++;
        end
        src_stop = 1'b1;
      end
    join
    est = exp_status(n, done_after, crc_at, resp_lo, rel);
    case (est)
      3: chk(int'(status) == est, "R3", {tag, " status"}, int'(status), est);
      4: chk(int'(status) == est, "R6", {tag, " status"}, int'(status), est);
      5: chk(int'(status) == est, "R8", {tag, " status"}, int'(status), est);
      default: chk(int'(status) == est, "R7", {tag, " status"}, int'(status), est);
    endcase
    chk(taken == exp_taken(n, est, crc_at), "R11", {tag, " bytes taken"},
        taken, exp_taken(n, est, crc_at));
    if (est == 3)
      chk(busy_cyc >= WAIT && busy_cyc <= WAIT + 8, "R3", {tag, " timeout length"},
          busy_cyc, WAIT);
    if (est == 2 || est == 5) begin
      chk(rx_n == n, "R4", {tag, " bytes received"}, rx_n, n);
      for (int i = 0; i < n; i++)
        chk(cap[i] == src[i], "R4", {tag, " byte value msb first"}, int'(cap[i]), int'(src[i]));
      chk(trail_bad == 0, "R7", {tag, " din low on trailing clock"}, trail_bad, 0);
    end
    if (est == 2)
      chk(trail_rises >= done_after, "R7", {tag, " trailing clocks"}, trail_rises, done_after);
    if (est == 5)
      chk(trail_rises > 0 && busy_cyc >= WAIT, "R8", {tag, " clocks until timeout"},
          trail_rises, 1);
    chk(din_bad == 0, "R5", {tag, " din moved at rising clock"}, din_bad, 0);
    repeat (2) @(negedge clk);
    chk(prog_n && !cclk && din && !s_ready, "R1", {tag, " pins quiet after end"},
        int'({prog_n, cclk, din, s_ready}), 4'b1010);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(prog_n && !cclk && din && !s_ready && status == 3'd0, "R1", "reset pins/status",
        int'({prog_n, cclk, din, s_ready, status}), 7'b1010000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(status == 3'd0, "R1", "idle status after reset", int'(status), 0);

    // directed: single byte, continuous stream
    run_load(1, 100, 1, -1, 1'b1, 1'b1, "one byte");
    // directed: zero bytes
    run_load(0, 100, 3, -1, 1'b1, 1'b1, "zero bytes");
    // random loads with varied stalls and done delays
    for (int t = 0; t < 8; t++) begin
      int n  = 1 + int'($urandom % 8);
      int dn = 10 + int'($urandom % 91);
      int da = 1 + int'($urandom % 5);
      run_load(n, dn, da, -1, 1'b1, 1'b1, "random");
    end
    // R6: integrity fault after byte 2 of 6
    run_load(6, 80, 2, 2, 1'b1, 1'b1, "crc fault");
    // R3: init never falls, then never rises
    run_load(4, 100, 2, -1, 1'b0, 1'b1, "init stuck high");
    run_load(4, 100, 2, -1, 1'b1, 1'b0, "init stuck low");
    // R8: done never rises
    run_load(3, 100, -1, -1, 1'b1, 1'b1, "done stuck low");

    // R9: readback request refused
    rb_req = 1'b1;
    @(negedge clk);
    rb_req = 1'b0;
    chk(status == 3'd6, "R9", "readback refused", int'(status), 6);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!prog_n || cclk || !din) begin
        chk(1'b0, "R9", "pins moved after readback", int'({prog_n, cclk, din}), 3'b101);
        break;
      end
    end
    // R10: status holds while idle
    repeat (40) @(negedge clk);
    chk(status == 3'd6, "R10", "status held while idle", int'(status), 6);
    run_load(2, 60, 2, -1, 1'b1, 1'b1, "after readback");
    repeat (40) @(negedge clk);
    chk(status == 3'd2, "R10", "ok status held", int'(status), 2);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule